// File: doc/BRIEF.md
# Voted-Control Stream Buffer

This block is a single-clock first-in first-out buffer that sits in front of a processing core and absorbs a continuously arriving sample stream while the consumer is temporarily slower. It holds 1024 samples of 12 bits in one storage array. It accepts a sample on every cycle that `wrValid` is high and space remains. A sample is released on every cycle that `rdStrobe` is high and data is present. The read side can be drained by a fast consumer every cycle or by a slow polling reader at any rate.

All bookkeeping state sits in three identical copies: the write pointer, the read pointer and the occupancy count. The address and wrap bit of each pointer are part of that state. A bitwise majority of the three copies drives the memory addresses, the full and empty flags and the reported fill level. A single corrupted copy therefore never reaches the outputs. Each copy is compared with the voted value. A copy that disagrees is flagged and reloaded from the voted state on the next clock edge.

An upset-injection input lets a test environment flip any chosen bits of any copy's stored state. The block treats such a flip exactly as it would treat a natural upset.

Top module: `voted_stream_fifo`

## Requirements
- R1: While and after reset, `empty` is 1, and `full`, `overflowErr`, `rdValid`, `fillLevel` and `replicaMismatch` are all 0.
- R2: Samples leave in the order they were accepted. An accepted read raises `rdValid` on the following cycle, and `rdData` carries the oldest stored sample during that cycle.
- R3: `full` is 1 exactly when 1024 samples are stored. A write attempted while `full` is 1 is dropped. It sets `overflowErr` from the next cycle, and the flag stays set until reset.
- R4: A read strobe while `empty` is 1 is ignored. `rdValid` stays 0 on the next cycle and `fillLevel` does not change.
- R5: A write and a read in the same cycle are both performed when the buffer is neither empty nor full, leaving `fillLevel` unchanged. When full, the read is performed and the write is dropped.
- R6: `fillLevel` always equals the number of stored samples (0 to 1024) and changes only on accepted writes and reads.
- R7: Flipping any bits in one state copy leaves `full`, `empty`, `fillLevel`, `rdValid`, `rdData` and the sample order unaffected.
- R8: One cycle after an upset is written into copy k, bit k of `replicaMismatch` is 1 for exactly one cycle, and the other bits stay 0.
- R9: A copy flagged as disagreeing is reloaded from the voted state at the next edge. Upsets later placed in a different copy are therefore masked too.
- R10: `upsetMask` holds one 33-bit field per copy, with copy k at bits [33k+32:33k]. Inside a field, bits [10:0] are the write pointer, [21:11] the read pointer and [32:22] the count. Bit 10 of each pointer is its wrap bit. Set bits are XORed into that copy at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request for `wrData` |
| wrData | input | 12 | Sample to store |
| rdStrobe | input | 1 | Read request |
| upsetMask | input | 99 | Per-copy bit flips applied to stored control state |
| rdData | output | 12 | Sample returned for the previous accepted read |
| rdValid | output | 1 | `rdData` is valid this cycle |
| full | output | 1 | 1024 samples stored |
| empty | output | 1 | No samples stored |
| fillLevel | output | 11 | Number of stored samples |
| overflowErr | output | 1 | Sticky: a write was dropped while full |
| replicaMismatch | output | 3 | One-cycle pulse per copy found to disagree |

## Verification
The bench builds the block with its default parameters: 10 address bits and 12 data bits. Filling all 1024 entries then takes about a thousand cycles. This makes the full boundary, the overflow drop and the read-while-full case reachable in a short run. A second fill after a complete drain carries both pointers past their wrap bit, which checks full and empty detection across the wrap. Single-bit upsets are aimed at the write pointer, read pointer and count fields of each copy in turn while traffic flows. A chain of upsets that lands the same bit in all three copies in succession only stays masked if every reload really takes place.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // number of control-state copies kept for voting
  localparam int NUM_REPLICAS = 3;

  // strobes handed from the control module to the storage datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } memStrobe_t;
endpackage

// File: rtl/fifo_tmr_ctrl.sv
module fifo_tmr_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   wrValid,
  input  logic                                   rdStrobe,
  input  logic [NUM_REPLICAS*3*(ADDR_W+1)-1:0]   upsetMask,
  output memStrobe_t                             strobe,
  output logic [ADDR_W-1:0]                      wrAddr,
  output logic [ADDR_W-1:0]                      rdAddr,
  output logic                                   full,
  output logic                                   empty,
  output logic [ADDR_W:0]                        fillLevel,
  output logic                                   overflowErr,
  output logic [NUM_REPLICAS-1:0]                replicaMismatch
);
  localparam int PTR_W   = ADDR_W + 1;
  localparam int STATE_W = 3 * PTR_W;

  // packed layout: count in the top field, write pointer in the bottom field
  typedef struct packed {
    logic [PTR_W-1:0] count;
    logic [PTR_W-1:0] rdPtr;
    logic [PTR_W-1:0] wrPtr;
  } ctrlState_t;

  logic [NUM_REPLICAS-1:0][STATE_W-1:0] repVec;
  logic [STATE_W-1:0]                   votedVec;
  ctrlState_t                           voted;
  ctrlState_t                           advanced;
  logic [NUM_REPLICAS-1:0]              minority;
  logic                                 doWr;
  logic                                 doRd;

  // bitwise two-of-three majority
  assign votedVec = (repVec[0] & repVec[1]) | (repVec[0] & repVec[2]) | (repVec[1] & repVec[2]);
  assign voted    = ctrlState_t'(votedVec);

  // flags from the voted pointers
  assign empty = (voted.wrPtr == voted.rdPtr);
  assign full  = (voted.wrPtr[ADDR_W] != voted.rdPtr[ADDR_W]) &&
                 (voted.wrPtr[ADDR_W-1:0] == voted.rdPtr[ADDR_W-1:0]);

  assign doWr = wrValid && !full;
  assign doRd = rdStrobe && !empty;

  always_comb begin
    advanced       = voted;
    advanced.wrPtr = voted.wrPtr + PTR_W'(doWr);
    advanced.rdPtr = voted.rdPtr + PTR_W'(doRd);
    advanced.count = voted.count + PTR_W'(doWr) - PTR_W'(doRd);
  end

  // one register copy per replica, each with its own minority detector
  for (genvar r = 0; r < NUM_REPLICAS; r++) begin : g_replica
    logic [STATE_W-1:0] stateQ;
    ctrlState_t         own;
    ctrlState_t         ownNext;
    ctrlState_t         nextVal;

    assign own         = ctrlState_t'(stateQ);
    assign minority[r] = (stateQ != votedVec);

    always_comb begin
      ownNext       = own;
      ownNext.wrPtr = own.wrPtr + PTR_W'(doWr);
      ownNext.rdPtr = own.rdPtr + PTR_W'(doRd);
      ownNext.count = own.count + PTR_W'(doWr) - PTR_W'(doRd);
      // a disagreeing copy is reloaded from the voted state
      nextVal       = minority[r] ? advanced : ownNext;
    end

    always_ff @(posedge clk) begin
      if (!rstN) stateQ <= '0;
      else       stateQ <= STATE_W'(nextVal) ^ upsetMask[r*STATE_W +: STATE_W];
    end

    assign repVec[r] = stateQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      replicaMismatch <= '0;
      overflowErr     <= 1'b0;
    end else begin
      replicaMismatch <= minority;
      if (wrValid && full) overflowErr <= 1'b1;
    end
  end

  assign strobe.wrEn = doWr;
  assign strobe.rdEn = doRd;
  assign wrAddr      = voted.wrPtr[ADDR_W-1:0];
  assign rdAddr      = voted.rdPtr[ADDR_W-1:0];
  assign fillLevel   = voted.count;
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= mem[rdAddr];
    end
  end
endmodule

// File: rtl/voted_stream_fifo.sv
module voted_stream_fifo
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrValid,
  input  logic [DATA_W-1:0]                    wrData,
  input  logic                                 rdStrobe,
  input  logic [NUM_REPLICAS*3*(ADDR_W+1)-1:0] upsetMask,
  output logic [DATA_W-1:0]                    rdData,
  output logic                                 rdValid,
  output logic                                 full,
  output logic                                 empty,
  output logic [ADDR_W:0]                      fillLevel,
  output logic                                 overflowErr,
  output logic [NUM_REPLICAS-1:0]              replicaMismatch
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  fifo_tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
    .upsetMask(upsetMask), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .empty(empty), .fillLevel(fillLevel),
    .overflowErr(overflowErr), .replicaMismatch(replicaMismatch)
  );

  fifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/fifo_tmr_checker.sv
module fifo_tmr_checker #(
  parameter int ADDR_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrValid,
  input logic            rdStrobe,
  input logic            full,
  input logic            empty,
  input logic [ADDR_W:0] fillLevel,
  input logic            overflowErr,
  input logic            rdValid,
  input logic [2:0]      replicaMismatch
);
  localparam int DEPTH = 1 << ADDR_W;

  p_full_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (fillLevel == (ADDR_W+1)'(DEPTH)));
  p_overflow_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrValid) |=> overflowErr);
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);
  p_empty_read_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdStrobe) |=> !rdValid);
  p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !rdStrobe) |=> $stable(fillLevel));
  p_empty_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (fillLevel == '0));
  p_one_copy_flagged_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(replicaMismatch));
  p_flag_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (replicaMismatch != 3'b000) |=> (replicaMismatch == 3'b000));
endmodule

bind voted_stream_fifo fifo_tmr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
  .full(full), .empty(empty), .fillLevel(fillLevel), .overflowErr(overflowErr),
  .rdValid(rdValid), .replicaMismatch(replicaMismatch)
);

// File: tb/tb_voted_stream_fifo.sv
module tb_voted_stream_fifo;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 12;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int FIELD_W = 3 * (ADDR_W + 1);
  localparam int MASK_W  = 3 * FIELD_W;
  localparam int WATCHDOG_CYCLES = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdStrobe = 1'b0;
  logic [MASK_W-1:0] upsetMask = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic              full;
  logic              empty;
  logic [ADDR_W:0]   fillLevel;
  logic              overflowErr;
  logic [2:0]        replicaMismatch;

  always #4 clk = ~clk;

  voted_stream_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .rdStrobe(rdStrobe),
    .upsetMask(upsetMask), .rdData(rdData), .rdValid(rdValid), .full(full),
    .empty(empty), .fillLevel(fillLevel), .overflowErr(overflowErr),
    .replicaMismatch(replicaMismatch)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string phase = "R1 reset";

  // behavioural reference
  int          q[$];
  bit          expOvf = 0;
  bit          expRdValid = 0;
  int          expRdData = 0;
  logic [2:0]  expMis = '0;
  logic [2:0]  pendMis = '0;
  int          seq = 0;

  task automatic checkVal(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal("empty", int'(empty), int'(q.size() == 0));
    checkVal("full", int'(full), int'(q.size() == DEPTH));
    checkVal("fillLevel", int'(fillLevel), q.size());
    checkVal("overflowErr", int'(overflowErr), int'(expOvf));
    checkVal("rdValid", int'(rdValid), int'(expRdValid));
    if (expRdValid) checkVal("rdData", int'(rdData), expRdData);
    checkVal("replicaMismatch", int'(replicaMismatch), int'(expMis));
  endtask

  function automatic logic [MASK_W-1:0] flipBit(int rep, int bitPos);
    logic [MASK_W-1:0] m = '0;
    m[rep*FIELD_W + bitPos] = 1'b1;
    return m;
  endfunction

  // drive one cycle at a falling edge, update the model, compare after the next rising edge
  task automatic step(bit wv, bit rs, logic [MASK_W-1:0] mask);
    bit fullNow;
    bit emptyNow;
    logic [DATA_W-1:0] wd;
    wd = DATA_W'(seq * 37 + 5);
    wrValid   = wv;
    wrData    = wd;
    rdStrobe  = rs;
    upsetMask = mask;
    fullNow   = (q.size() == DEPTH);
    emptyNow  = (q.size() == 0);
    expRdValid = 0;
    if (rs && !emptyNow) begin
      expRdData  = q.pop_front();
      expRdValid = 1;
    end
    if (wv && !fullNow) begin
      q.push_back(int'(wd));
      seq++;
    end
    if (wv && fullNow) expOvf = 1;
    expMis  = pendMis;
    pendMis = {|mask[2*FIELD_W +: FIELD_W], |mask[FIELD_W +: FIELD_W], |mask[0 +: FIELD_W]};
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", WATCHDOG_CYCLES);
    finishRun();
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll();
    rstN = 1'b1;
    step(0, 0, '0);

    // R4: reads on an empty buffer are ignored
    phase = "R4 read while empty";
    repeat (3) step(0, 1, '0);

    // R2: ordered stream with gaps on the read side
    phase = "R2 ordered stream";
    for (int i = 0; i < 16; i++) step(1, 0, '0);
    for (int i = 0; i < 16; i++) begin
      step(0, 1, '0);
      step(0, 0, '0);
    end

    // R5: concurrent write and read
    phase = "R5 concurrent read and write";
    for (int i = 0; i < 5; i++) step(1, 0, '0);
    for (int i = 0; i < 20; i++) step(1, 1, '0);
    for (int i = 0; i < 5; i++) step(0, 1, '0);

    // R3 and R6: fill to the boundary, overflow, drain
    phase = "R3 R6 fill to full";
    for (int i = 0; i < DEPTH; i++) step(1, 0, '0);
    phase = "R3 write while full dropped";
    for (int i = 0; i < 4; i++) step(1, 0, '0);
    phase = "R5 read and write while full";
    step(1, 1, '0);
    step(1, 0, '0);
    phase = "R6 drain after wrap";
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, '0);

    // R7 R8 R10: single upsets in each field of each copy under traffic
    phase = "R7 R8 R10 upsets under traffic";
    for (int i = 0; i < 40; i++) step(1, 0, '0);
    for (int rep = 0; rep < 3; rep++) begin
      for (int f = 0; f < 3; f++) begin
        for (int b = 0; b <= ADDR_W; b += 5) begin
          step(1, 1, flipBit(rep, f * (ADDR_W + 1) + b));
          step(1, 0, '0);
          step(0, 1, '0);
        end
      end
    end

    // R9: the same bit hit in every copy in turn, only masked if each is reloaded
    phase = "R9 repair before next upset";
    for (int b = 0; b < FIELD_W; b += 4) begin
      for (int rep = 0; rep < 3; rep++) begin
        step(1, 1, flipBit(rep, b));
        step(0, 0, '0);
        step(1, 1, '0);
      end
    end

    phase = "R2 final drain order";
    while (q.size() > 0) step(0, 1, '0);
    step(0, 1, '0);
    step(0, 0, '0);

    finishRun();
  end
endmodule